// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit operands and a carry-in with no clock. The operand width is split into four groups of four bits. Every bit forms its own generate (both operand bits set) and propagate (either operand bit set) terms. Every group turns those into a group generate, a group propagate and its own internal carries. A second-level lookahead unit then computes the carry into each group directly from the group terms and the external carry-in. No carry passes from one group to the next through a ripple chain, and no carry is built from one flat sixteen-input equation.

The block also exposes the block-level generate and propagate of the full width. A wider adder can therefore place this block under a third lookahead level without changing it. Subtraction, overflow flags and pipeline registers belong to the surrounding datapath and are not part of this block.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `opa + opb + cin`, computed as unsigned numbers.
- R2: `cout` equals bit 16 of the 17-bit unsigned result of `opa + opb + cin`.
- R3: `grp_prop` is 1 exactly when every one of the 16 bit positions has at least one operand bit set, that is when `(opa | opb) == 16'hFFFF`.
- R4: `grp_gen` is 1 exactly when `opa + opb` with carry-in 0 produces a carry out of bit 15.
- R5: `cout` equals `grp_gen | (grp_prop & cin)` for every input.
- R6: A carry crosses the whole width without loss. `16'hFFFF + 16'h0001` with `cin`=0 gives `sum`=0 and `cout`=1. `16'hFFFF + 16'h0000` with `cin`=1 gives `sum`=0 and `cout`=1. `16'hFFFF + 16'h0001` with `cin`=1 gives `sum`=1 and `cout`=1.
- R7: The carry that the second-level unit delivers into group j (j = 1..3) equals the carry that group j-1 produces from its own inputs. The sums of the upper groups therefore match the arithmetic result for every carry pattern across group boundaries.
- R8: The outputs are a pure function of the present inputs. They settle within the same time step as an input change and keep no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_gen | output | 1 | Block-level generate of all 16 bits |
| grp_prop | output | 1 | Block-level propagate of all 16 bits |

## Verification
The checks are immediate assertions evaluated on combinational nets. They assume that the operands and the carry-in are always driven to known 0/1 values and never to X or Z. The bench holds every input at a defined value from time zero and changes the inputs only between samples. The assertions also assume that each check reads settled values. For that reason the bench waits a fixed delay after each change before it samples anything.

The stimulus sweeps every combination of two 8-bit values and both carry-in values. Each 8-bit value is mirrored into both bytes of its operand, so every bit-level pattern appears at each group boundary. Random vectors and the full-length carry chains follow the sweep.

// File: rtl/cla_pkg.sv
// Package: shared sizing and the per-bit term pair for the lookahead adder.
// Assumes: group width times group count gives the operand width.
package cla_pkg;
    parameter int GRP_W   = 4;
    parameter int NUM_GRP = 4;
    localparam int DATA_W = GRP_W * NUM_GRP;

    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;
endpackage

// File: rtl/cla_bit_pg.sv
// Module: per-bit term generator.
// For each bit it forms the generate term (AND), the propagate term (OR),
// and the half-sum (XOR) that the sum stage needs.
// Assumes: both operands are known values of the same width.
module cla_bit_pg
    import cla_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o,
    output logic [W-1:0] half_o
);
    // Purpose: pack the terms into a struct so every bit is formed in one place.
    for (genvar i = 0; i < W; i++) begin : g_bit
        pg_t term;
        assign term.gen  = a_i[i] & b_i[i];
        assign term.prop = a_i[i] | b_i[i];
        assign gen_o[i]  = term.gen;
        assign prop_o[i] = term.prop;
        assign half_o[i] = a_i[i] ^ b_i[i];
    end

    // Purpose: a bit that generates must also propagate (R3 term consistency).
    always_comb begin
        a_r3_gen_implies_prop: assert ((gen_o & ~prop_o) == '0)
            else $error("generate set without propagate");
    end
endmodule

// File: rtl/cla_carry_net.sv
// Module: one lookahead level.
// Computes every carry as a flat sum of products over the generate and
// propagate inputs and the carry-in, so no carry waits on a lower carry.
// It also forms the level's block generate and block propagate.
// Used both inside a group (bit terms) and across groups (group terms).
// Assumes: N is small (the term count grows with N squared).
module cla_carry_net #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin,
    output logic [N:0]   carry_o,
    output logic         blk_g_o,
    output logic         blk_p_o
);
    // Purpose: build carry i from all lower generates and the carry-in in parallel.
    always_comb begin
        logic acc;
        logic term;
        carry_o    = '0;
        carry_o[0] = cin;
        for (int i = 1; i <= N; i++) begin
            acc = cin;
            for (int m = 0; m < i; m++) acc = acc & prop_i[m];
            for (int k = 0; k < i; k++) begin
                term = gen_i[k];
                for (int m = k + 1; m < i; m++) term = term & prop_i[m];
                acc = acc | term;
            end
            carry_o[i] = acc;
        end
    end

    // Purpose: block generate, the top carry with the carry-in forced to 0.
    always_comb begin
        logic term;
        blk_g_o = 1'b0;
        for (int k = 0; k < N; k++) begin
            term = gen_i[k];
            for (int m = k + 1; m < N; m++) term = term & prop_i[m];
            blk_g_o = blk_g_o | term;
        end
    end

    // Purpose: block propagate, the AND of all propagates.
    assign blk_p_o = &prop_i;

    // Purpose: the top carry must agree with the block terms (R5).
    always_comb begin
        a_r5_top_carry_blk: assert (carry_o[N] == (blk_g_o | (blk_p_o & cin)))
            else $error("top carry disagrees with block terms");
    end
endmodule

// File: rtl/cla_group.sv
// Module: one adder group of W bits.
// It forms the bit terms, computes the internal carries through a lookahead
// level, and produces the sum bits plus its group generate and propagate.
// Its local carry-out is exported for cross-checking only. The carry between
// groups comes from the second level.
// Assumes: cin is the carry delivered by the second-level unit.
module cla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin,
    output logic [W-1:0] sum_o,
    output logic         grp_g_o,
    output logic         grp_p_o,
    output logic         cout_local_o
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W-1:0] half;
    logic [W:0]   carry;

    // Purpose: bit-level generate, propagate and half-sum.
    cla_bit_pg #(.W(W)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (gen),
        .prop_o (prop),
        .half_o (half)
    );

    // Purpose: in-group carries in sum-of-products form.
    cla_carry_net #(.N(W)) u_net (
        .gen_i   (gen),
        .prop_i  (prop),
        .cin     (cin),
        .carry_o (carry),
        .blk_g_o (grp_g_o),
        .blk_p_o (grp_p_o)
    );

    // Purpose: sum uses XOR, since the OR-based propagate is valid only for carries.
    assign sum_o        = half ^ carry[W-1:0];
    assign cout_local_o = carry[W];

    // Purpose: a generating group always carries out; a group that neither
    // generates nor propagates never does (R4).
    always_comb begin
        a_r4_group_gen_carry: assert (!grp_g_o || cout_local_o)
            else $error("group generate without carry-out");
        a_r4_group_kill: assert (grp_g_o || grp_p_o || !cout_local_o)
            else $error("killing group produced a carry-out");
    end
endmodule

// File: rtl/cla16_adder.sv
// Module: two-level carry lookahead adder (top).
// Four groups produce group terms. A second lookahead level turns those terms
// and the external carry-in into every group carry-in and the carry-out.
// Purely combinational; no clock, no reset, no state.
// Assumes: inputs are known 0/1 values.
module cla16_adder
    import cla_pkg::*;
#(
    parameter int GW = GRP_W,
    parameter int NG = NUM_GRP,
    localparam int DW = GW * NG
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          grp_gen,
    output logic          grp_prop
);
    logic [NG-1:0] g_grp;
    logic [NG-1:0] p_grp;
    logic [NG-1:0] cout_loc;
    logic [NG:0]   c_grp;

    // Purpose: one group instance per slice, fed by the second-level carries.
    for (genvar j = 0; j < NG; j++) begin : g_grp_inst
        cla_group #(.W(GW)) u_grp (
            .a_i          (opa[j*GW +: GW]),
            .b_i          (opb[j*GW +: GW]),
            .cin          (c_grp[j]),
            .sum_o        (sum[j*GW +: GW]),
            .grp_g_o      (g_grp[j]),
            .grp_p_o      (p_grp[j]),
            .cout_local_o (cout_loc[j])
        );
    end

    // Purpose: second-level lookahead over the group terms.
    cla_carry_net #(.N(NG)) u_lookahead (
        .gen_i   (g_grp),
        .prop_i  (p_grp),
        .cin     (cin),
        .carry_o (c_grp),
        .blk_g_o (grp_gen),
        .blk_p_o (grp_prop)
    );

    assign cout = c_grp[NG];

    // Purpose: end-to-end arithmetic (R1, R2) and group handoff (R7).
    always_comb begin
        logic [DW:0] ref_total;
        ref_total = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
        a_r1_sum_value: assert (sum == ref_total[DW-1:0])
            else $error("sum mismatch");
        a_r2_carry_out: assert (cout == ref_total[DW])
            else $error("carry-out mismatch");
        for (int j = 1; j < NG; j++) begin
            a_r7_group_link: assert (c_grp[j] == cout_loc[j-1])
                else $error("group carry handoff mismatch at %0d", j);
        end
    end
endmodule

// File: tb/cla16_adder_test.sv
`timescale 1ns/1ps
module cla16_adder_test;
    logic        clk = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    logic        grp_gen;
    logic        grp_prop;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    cla16_adder uut (
        .opa      (opa),
        .opb      (opb),
        .cin      (cin),
        .sum      (sum),
        .cout     (cout),
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop)
    );

    // Drive one vector, wait for settling, compare all outputs against arithmetic.
    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c,
                         input string tag);
        logic [16:0] tot;
        logic [16:0] tot0;
        logic        ep;
        opa = a; opb = b; cin = c;
        #1;
        tot  = {1'b0, a} + {1'b0, b} + {16'd0, c};
        tot0 = {1'b0, a} + {1'b0, b};
        ep   = ((a | b) == 16'hFFFF);
        n_run++;
        if (sum !== tot[15:0]) begin
            n_fail++;
            $display("FAIL R1 %s a=%h b=%h c=%0b sum=%h expected %h", tag, a, b, c, sum, tot[15:0]);
        end else if (cout !== tot[16]) begin
            n_fail++;
            $display("FAIL R2 %s a=%h b=%h c=%0b cout=%0b expected %0b", tag, a, b, c, cout, tot[16]);
        end else if (grp_prop !== ep) begin
            n_fail++;
            $display("FAIL R3 %s a=%h b=%h grp_prop=%0b expected %0b", tag, a, b, grp_prop, ep);
        end else if (grp_gen !== tot0[16]) begin
            n_fail++;
            $display("FAIL R4 %s a=%h b=%h grp_gen=%0b expected %0b", tag, a, b, grp_gen, tot0[16]);
        end else if (cout !== (tot0[16] | (ep & c))) begin
            n_fail++;
            $display("FAIL R5 %s cout=%0b expected %0b", tag, cout, tot0[16] | (ep & c));
        end
    endtask

    // Fixed-value check used for the named corner cases.
    task automatic expect_val(input logic [15:0] a, input logic [15:0] b, input logic c,
                              input logic [15:0] es, input logic ec, input string tag);
        opa = a; opb = b; cin = c;
        #1;
        n_run++;
        if (sum !== es || cout !== ec) begin
            n_fail++;
            $display("FAIL %s sum=%h cout=%0b expected sum=%h cout=%0b", tag, sum, cout, es, ec);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Idle state with all-zero inputs (R8: no state, outputs follow inputs).
        expect_val(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R8 idle zero");

        // R6 full-length propagate chains.
        expect_val(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, "R6 ffff+1 c0");
        expect_val(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R6 ffff+0 c1");
        expect_val(16'hFFFF, 16'h0001, 1'b1, 16'h0001, 1'b1, "R6 ffff+1 c1");
        apply(16'hFFFF, 16'h0000, 1'b0, "R3 all-propagate no carry");
        apply(16'h8000, 16'h8000, 1'b0, "R4 top generate");

        // R7 carries crossing each group boundary alone.
        for (int j = 0; j < 3; j++) begin
            apply(16'h000F << (4 * j), 16'h0001 << (4 * j), 1'b0, "R7 boundary cross");
            apply(16'h000F << (4 * j), 16'h0000, 1'b1, "R7 boundary cin");
        end

        // Near-exhaustive sweep: each byte mirrored into both halves (R1..R5, R7).
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    apply({a[7:0], a[7:0]}, {b[7:0], b[7:0]}, c[0], "sweep");
                end
            end
        end

        // Random vectors across the full width.
        for (int i = 0; i < 20000; i++) begin
            apply($urandom, $urandom, $urandom_range(0, 1), "random");
        end

        // R8: returning to a prior vector gives the same result with no memory.
        expect_val(16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, "R8 repeat a");
        expect_val(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, "R8 other");
        expect_val(16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, "R8 repeat b");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule